// File: doc/BRIEF.md
# UART Word Packet Assembler

This block sits behind a UART receiver and groups its decoded words into packets. Each word arrives on a valid strobe. The block forwards every word one clock later as a registered stream that carries first and last flags. It also pulses a packet-complete output on the cycle that carries a packet's final word.

Two closing conditions can end a packet, and each one can be switched on or off:

- **Delimiter match:** the word equals a programmed delimiter value. The matching word is the last word of its packet.
- **Length reached:** the word count of the packet reaches a programmed maximum.

When both conditions are enabled, whichever fires first closes the packet. When both are off, words pass straight through with no packet marking. A synchronous clear drops a partial packet without emitting anything for it.

Top module: `uart_pkt_assembler`

## Requirements
- R1: Every word accepted with `in_valid` high and `clr` low appears on `out_data` with `out_valid` high exactly one cycle later. In every other cycle `out_valid` is low.
- R2: With the delimiter check enabled, a word equal to `delim_value` is forwarded with `out_last` high. It is therefore the final word of its packet.
- R3: With the length check enabled and `len_max` non-zero, the word that brings the packet's word count to `len_max` carries `out_last`. A `len_max` of 0 disables the length check.
- R4: With both checks enabled, the first condition met closes the packet. The word count then restarts, so the next packet is measured from its own first word.
- R5: `out_first` is high on the first word forwarded after reset, after a closed packet, and after a clear, provided at least one check is enabled.
- R6: With both checks disabled, words pass through unchanged, and `out_first`, `out_last` and `pkt_done` stay low.
- R7: When `clr` is high, any partial packet is dropped. The word offered in that cycle is discarded, `out_valid` is low in the following cycle, and the next accepted word is marked first.
- R8: `pkt_done` pulses high for one cycle, together with `out_valid` and `out_last`, for each closed packet. It is low otherwise.
- R9: The delimiter compare uses all `DATA_W` bits (default 9). For example, 0x10A does not match a delimiter of 0x00A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the partial packet |
| in_valid | input | 1 | Input word strobe |
| in_data | input | DATA_W | Decoded UART word |
| delim_en | input | 1 | Enables the delimiter condition |
| delim_value | input | DATA_W | Delimiter word |
| len_en | input | 1 | Enables the length condition |
| len_max | input | LEN_W | Maximum packet length in words (0 = off) |
| out_valid | output | 1 | Output word strobe |
| out_data | output | DATA_W | Forwarded word |
| out_first | output | 1 | First word of a packet |
| out_last | output | 1 | Last word of a packet |
| pkt_done | output | 1 | Packet-complete pulse |

## Verification
The directed cases cover the following:

- **Delimiter only:** the delimiter word must carry the last flag.
- **Length only, including a length of one:** every word must be both first and last.
- **Both checks enabled:** a delimiter arrives before the length limit, and the length limit is reached with no delimiter. This separates an OR of the two conditions from either condition alone.
- **Delimiter vs a word with only the top bit flipped:** this exposes a compare that is too narrow.
- **Clear mid-packet:** checks that the partial packet is dropped, the word in the clear cycle is discarded, and the next word is marked first.
- **Both checks disabled:** the stream must carry no marks.

Constrained random traffic then mixes idle gaps, small alphabets that make delimiter hits frequent, and random configurations. It is checked word by word against a bench model of the packet state.

// File: rtl/uart_pkt_pkg.sv
package uart_pkt_pkg;
  typedef struct packed {
    logic first;
    logic last;
  } pkt_mark_t;
endpackage

// File: rtl/pkt_term_detect.sv
module pkt_term_detect #(
  parameter int DATA_W = 9,
  parameter int LEN_W  = 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic              delim_en,
  input  logic [DATA_W-1:0] delim_value,
  input  logic              len_en,
  input  logic [LEN_W-1:0]  len_max,
  input  logic [LEN_W-1:0]  count,
  output logic              marking,
  output logic              close
);
  localparam int CW = LEN_W + 1;
  logic [CW-1:0] next_count;
  logic          len_active;
  logic          hit_delim;
  logic          hit_len;

  always_comb begin
    len_active = len_en && (len_max != '0);
    next_count = {1'b0, count} + CW'(1);
    hit_delim  = delim_en && (word == delim_value);
    hit_len    = len_active && (next_count == {1'b0, len_max});
    marking    = delim_en || len_active;
    close      = hit_delim || hit_len;
  end
endmodule

// File: rtl/pkt_word_counter.sv
module pkt_word_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             close,
  output logic [LEN_W-1:0] count,
  output logic             in_pkt
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count  <= '0;
      in_pkt <= 1'b0;
    end else if (step) begin
      if (close) begin
        count  <= '0;
        in_pkt <= 1'b0;
      end else begin
        in_pkt <= 1'b1;
        if (count != CNT_MAX) count <= count + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/pkt_out_stage.sv
module pkt_out_stage
  import uart_pkt_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] word,
  input  pkt_mark_t         mark,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              pkt_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      pkt_done  <= 1'b0;
    end else begin
      out_valid <= take;
      pkt_done  <= take && mark.last;
      if (take) begin
        out_data  <= word;
        out_first <= mark.first;
        out_last  <= mark.last;
      end else begin
        out_first <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_pkt_assembler.sv
module uart_pkt_assembler
  import uart_pkt_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              delim_en,
  input  logic [DATA_W-1:0] delim_value,
  input  logic              len_en,
  input  logic [LEN_W-1:0]  len_max,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              pkt_done
);
  logic             take;
  logic             marking;
  logic             close;
  logic             in_pkt;
  logic [LEN_W-1:0] count;
  pkt_mark_t        mark;

  assign take = in_valid && !clr;

  pkt_term_detect #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_detect (
    .word(in_data), .delim_en(delim_en), .delim_value(delim_value),
    .len_en(len_en), .len_max(len_max), .count(count),
    .marking(marking), .close(close)
  );

  pkt_word_counter #(.LEN_W(LEN_W)) u_count (
    .clk(clk), .rst(rst), .clr(clr), .step(take && marking),
    .close(close), .count(count), .in_pkt(in_pkt)
  );

  always_comb begin
    mark.first = marking && !in_pkt;
    mark.last  = marking && close;
  end

  pkt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .take(take), .word(in_data), .mark(mark),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .pkt_done(pkt_done)
  );
endmodule

// File: rtl/uart_pkt_assembler_chk.sv
module uart_pkt_assembler_chk #(
  parameter int DATA_W = 9,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              delim_en,
  input logic [DATA_W-1:0] delim_value,
  input logic              len_en,
  input logic [LEN_W-1:0]  len_max,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_first,
  input logic              out_last,
  input logic              pkt_done
);
  a_r1_word_forwarded: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clr) |=> (out_valid && out_data == $past(in_data)));
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !clr) |=> !out_valid);
  a_r2_delim_closes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clr && delim_en && in_data == delim_value) |=> out_last);
  a_r6_no_marks: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !delim_en && !(len_en && len_max != '0)) |=> (!out_first && !out_last));
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_valid);
  a_r8_done_with_last: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (out_valid && out_last));
  a_r8_last_has_done: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> pkt_done);
endmodule

bind uart_pkt_assembler uart_pkt_assembler_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_data(in_data),
  .delim_en(delim_en), .delim_value(delim_value), .len_en(len_en),
  .len_max(len_max), .out_valid(out_valid), .out_data(out_data),
  .out_first(out_first), .out_last(out_last), .pkt_done(pkt_done)
);

// File: tb/tb_uart_pkt_assembler.sv
module tb_uart_pkt_assembler;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 9;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst, clr, in_valid, delim_en, len_en;
  logic [DATA_W-1:0] in_data, delim_value;
  logic [LEN_W-1:0]  len_max;
  logic              out_valid, out_first, out_last, pkt_done;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  bit m_inpkt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_pkt_assembler #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .delim_en(delim_en), .delim_value(delim_value), .len_en(len_en),
    .len_max(len_max), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .pkt_done(pkt_done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit marking_on();
    return delim_en || (len_en && len_max != 0);
  endfunction

  function automatic bit closes(logic [DATA_W-1:0] d);
    return (delim_en && d == delim_value) ||
           (len_en && len_max != 0 && m_cnt + 1 == int'(len_max));
  endfunction

  // One cycle: drive at negedge, sample 1 time unit after the next posedge.
  task automatic step(bit v, logic [DATA_W-1:0] d, bit c, string req);
    bit e_first, e_last, e_take, mk;
    @(negedge clk);
    in_valid = v; in_data = d; clr = c;
    e_take  = v && !c;
    mk      = marking_on();
    e_first = e_take && mk && !m_inpkt;
    e_last  = e_take && mk && closes(d);
    if (c) begin
      m_cnt = 0; m_inpkt = 0;
    end else if (e_take && mk) begin
      if (e_last) begin m_cnt = 0; m_inpkt = 0; end
      else begin m_inpkt = 1; if (m_cnt < 255) m_cnt++; end
    end
    @(posedge clk); #1;
    check({req, " valid"}, 32'(out_valid), 32'(e_take));
    if (e_take) check({req, " data"}, 32'(out_data), 32'(d));
    check({req, " first"}, 32'(out_first), 32'(e_first));
    check({req, " last"}, 32'(out_last), 32'(e_last));
    check({req, " done"}, 32'(pkt_done), 32'(e_last));
  endtask

  task automatic config_set(bit de, logic [DATA_W-1:0] dv, bit le, logic [LEN_W-1:0] lm);
    step(1'b0, '0, 1'b1, "R7 cfg-clear");
    delim_en = de; delim_value = dv; len_en = le; len_max = lm;
  endtask

  initial begin
    rst = 1; clr = 0; in_valid = 0; in_data = '0;
    delim_en = 0; delim_value = '0; len_en = 0; len_max = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", 32'(out_valid), 0);
    check("R8 reset done", 32'(pkt_done), 0);
    @(negedge clk); rst = 0;

    // R2 delimiter only
    config_set(1, 9'h00A, 0, 0);
    step(1, 9'h041, 0, "R5 R2 first");
    step(1, 9'h042, 0, "R2 mid");
    step(1, 9'h00A, 0, "R2 delim last");
    step(0, '0, 0, "R1 idle");
    // R9 full-width compare
    step(1, 9'h10A, 0, "R9 top bit differs");
    step(1, 9'h00A, 0, "R9 exact match");
    // R3 length only, 3 and 1, and 0 meaning off
    config_set(0, 9'h00A, 1, 8'd3);
    for (int i = 0; i < 7; i++) step(1, 9'(i), 0, "R3 len3");
    config_set(0, 9'h00A, 1, 8'd1);
    for (int i = 0; i < 3; i++) step(1, 9'(i + 5), 0, "R3 len1");
    config_set(0, 9'h00A, 1, 8'd0);
    for (int i = 0; i < 3; i++) step(1, 9'(i), 0, "R3 R6 len0 off");
    // R4 both enabled
    config_set(1, 9'h0FF, 1, 8'd4);
    step(1, 9'h001, 0, "R4 a");
    step(1, 9'h0FF, 0, "R4 delim first");
    for (int i = 0; i < 5; i++) step(1, 9'(i + 16), 0, "R4 len first");
    // R7 clear mid-packet
    step(1, 9'h011, 0, "R7 pre");
    step(1, 9'h012, 1, "R7 word in clear dropped");
    step(1, 9'h013, 0, "R7 next is first");
    // R6 both disabled
    config_set(0, 9'h013, 0, 8'd2);
    for (int i = 0; i < 4; i++) step(1, 9'h013, 0, "R6 passthru");

    // Random traffic
    void'($urandom(32'd20240611));
    for (int blk = 0; blk < 40; blk++) begin
      config_set(1'($urandom), 9'($urandom_range(0, 7)), 1'($urandom),
                 8'($urandom_range(0, 6)));
      for (int k = 0; k < 60; k++)
        step(($urandom_range(0, 3) != 0), 9'($urandom_range(0, 7)) | ($urandom_range(0, 9) == 0 ? 9'h100 : 9'h0),
             ($urandom_range(0, 29) == 0), "R1 R2 R3 R4 R5 R7 R8 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule